// File: doc/BRIEF.md
# Accumulator Processor with Segment-then-Page Address Translation

This block is a small 8-bit accumulator machine whose every memory reference passes through two translation stages. The first stage reads a two-byte segment descriptor that holds a base and a length. The second stage reads a one-byte page descriptor that supplies a frame number. The physical store is 32 bytes, arranged as eight frames of four bytes each. All descriptors, code and data sit in this same array, which the environment fills through a load port before a run.

A run begins with a `start` pulse. The pulse samples the locations of the segment descriptor pair and the page descriptor table. Instructions are then fetched one at a time from the code segment, starting at offset 0. Each memory operand is taken from the data segment. The run ends on a halt instruction, or on a segment-length violation, which raises `fault`. The accumulator and a combinational peek port show the results.

Top module: `segpage_cpu`

## Requirements
- R1: After reset, `busy`, `halted` and `fault` are 0 and `acc` is 0.
- R2: An instruction byte has the opcode in bits 7:5 and the operand in bits 3:0. The opcodes are 001 load (acc = M), 010 add (acc = acc + M) and 011 subtract (acc = acc - M). Results wrap modulo 256.
- R3: Opcode 100 writes `acc` to the translated operand location and leaves `acc` unchanged.
- R4: Translation for segment s (0 = code, 1 = data) and offset o works as follows:
  - The base is read at byte `stbl_base + 2s` and the length at `stbl_base + 2s + 1`.
  - The linear address is (base + o) mod 32.
  - The frame is the low 3 bits of the byte at `ptbl_base + linear[4:2]`.
  - The physical address is {frame, linear[1:0]}.
- R5: Fetches use segment 0, with an offset that starts at 0 on `start` and increases by one per fetch. Operands always use segment 1, and bit 4 of the instruction has no effect.
- R6: An offset greater than or equal to the segment length sets `fault` and `halted`. Nothing further is executed, and `acc` keeps its value.
- R7: Opcode 111 sets `halted`. `halted` and `acc` then hold until the next `start`.
- R8: Opcodes 000, 101 and 110 access no operand and change neither `acc` nor memory.
- R9: An instruction with an operand takes 8 cycles. A halt or no-op fetch takes 4 cycles. A data-segment fault appears 2 cycles into the operand access, and a code-segment fault 2 cycles into the fetch.
- R10: Load-port writes are ignored while `busy` is 1.
- R11: `start` while not busy clears `halted` and `fault` and sets `busy` on the next cycle. It samples `stbl_base` and `ptbl_base` for the whole run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run from code offset 0 |
| stbl_base | input | 5 | Byte address of the segment descriptor pair |
| ptbl_base | input | 5 | Byte address of the page descriptor table |
| ld_we | input | 1 | Load-port write enable |
| ld_addr | input | 5 | Load-port byte address |
| ld_data | input | 8 | Load-port write data |
| peek_addr | input | 5 | Inspection read address |
| peek_data | output | 8 | Inspection read data (combinational) |
| acc | output | 8 | Accumulator |
| busy | output | 1 | A run is in progress |
| halted | output | 1 | Run ended by halt or fault |
| fault | output | 1 | Run ended by a segment-length violation |

## Verification
The assertions assume three things about the inputs:
- `start` is pulsed for a single cycle.
- The environment never needs the load port to act during a run.
- Reset is asserted before any run.

Under those assumptions, the checks are that `halted` and the accumulator stay still when no new start arrives, and that processor-side writes happen only while busy. The stimulus drives `start` for exactly one cycle, after the previous run has ended. It fills memory only while idle, apart from one deliberate write during a run that checks R10. It places the descriptors so that each test reaches a defined halt or fault.

// File: rtl/segpage_pkg.sv
package segpage_pkg;
    localparam int AW        = 5;
    localparam int DW        = 8;
    localparam int OFF_W     = 4;
    localparam int PG_W      = 2;
    localparam int FR_W      = AW - PG_W;
    localparam int OP_W      = 3;
    localparam int MEM_DEPTH = 1 << AW;

    localparam logic [OP_W-1:0] OP_LOAD  = 3'b001;
    localparam logic [OP_W-1:0] OP_ADD   = 3'b010;
    localparam logic [OP_W-1:0] OP_SUB   = 3'b011;
    localparam logic [OP_W-1:0] OP_STORE = 3'b100;
    localparam logic [OP_W-1:0] OP_HALT  = 3'b111;

    typedef enum logic [3:0] {
        ST_IDLE, ST_F_SB, ST_F_SL, ST_F_PT, ST_F_RD,
        ST_O_SB, ST_O_SL, ST_O_PT, ST_O_AC, ST_HALT, ST_FAULT
    } state_e;

    typedef enum logic [1:0] {PH_SEGBASE, PH_SEGLEN, PH_PTE, PH_DATA} phase_e;

    typedef struct packed {
        state_e           st;
        logic [OFF_W-1:0] pc;
        logic [OP_W-1:0]  op;
        logic [OFF_W-1:0] opnd;
        logic [DW-1:0]    acc;
        logic [AW-1:0]    sbase;
        logic [FR_W-1:0]  frame;
        logic [AW-1:0]    stb;
        logic [AW-1:0]    ptb;
    } core_t;
endpackage

// File: rtl/segpage_mem.sv
module segpage_mem #(
    parameter int AW = 5,
    parameter int DW = 8,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata,
    input  logic [AW-1:0] paddr,
    output logic [DW-1:0] pdata
);
    logic [DW-1:0] cells_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells_q[waddr] <= wdata;
        end
    end

    assign rdata = cells_q[raddr];
    assign pdata = cells_q[paddr];
endmodule

// File: rtl/segpage_xlat.sv
module segpage_xlat
    import segpage_pkg::*;
#(
    parameter int XAW   = AW,
    parameter int XOFF  = OFF_W,
    parameter int XPG   = PG_W,
    localparam int XFR  = XAW - XPG
) (
    input  phase_e         phase,
    input  logic           seg,
    input  logic [XOFF-1:0] off,
    input  logic [XAW-1:0] stb,
    input  logic [XAW-1:0] ptb,
    input  logic [XAW-1:0] sbase,
    input  logic [XFR-1:0] frame,
    output logic [XAW-1:0] addr
);
    logic [XAW-1:0] desc_a;
    logic [XAW-1:0] lin;

    always_comb begin
        desc_a = stb + {{(XAW-2){1'b0}}, seg, 1'b0};
        lin    = sbase + {{(XAW-XOFF){1'b0}}, off};
        unique case (phase)
            PH_SEGBASE: addr = desc_a;
            PH_SEGLEN:  addr = desc_a + {{(XAW-1){1'b0}}, 1'b1};
            PH_PTE:     addr = ptb + {{XPG{1'b0}}, lin[XAW-1:XPG]};
            default:    addr = {frame, lin[XPG-1:0]};
        endcase
    end
endmodule

// File: rtl/segpage_alu.sv
module segpage_alu
    import segpage_pkg::*;
#(
    parameter int ADW = DW
) (
    input  logic [OP_W-1:0] op,
    input  logic [ADW-1:0]  acc,
    input  logic [ADW-1:0]  operand,
    output logic [ADW-1:0]  result
);
    always_comb begin
        unique case (op)
            OP_LOAD: result = operand;
            OP_ADD:  result = acc + operand;
            OP_SUB:  result = acc - operand;
            default: result = acc;
        endcase
    end
endmodule

// File: rtl/segpage_cpu.sv
module segpage_cpu
    import segpage_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] stbl_base,
    input  logic [AW-1:0] ptbl_base,
    input  logic          ld_we,
    input  logic [AW-1:0] ld_addr,
    input  logic [DW-1:0] ld_data,
    input  logic [AW-1:0] peek_addr,
    output logic [DW-1:0] peek_data,
    output logic [DW-1:0] acc,
    output logic          busy,
    output logic          halted,
    output logic          fault
);
    core_t q, d;

    phase_e           phase;
    logic             seg_sel;
    logic [OFF_W-1:0] off_sel;
    logic [AW-1:0]    xaddr;
    logic [DW-1:0]    rdata;
    logic [DW-1:0]    alu_out;
    logic             cpu_we;
    logic             mem_we;
    logic [AW-1:0]    mem_waddr;
    logic [DW-1:0]    mem_wdata;
    logic             len_bad;

    segpage_xlat u_xlat (
        .phase(phase), .seg(seg_sel), .off(off_sel),
        .stb(q.stb), .ptb(q.ptb), .sbase(q.sbase), .frame(q.frame),
        .addr(xaddr)
    );

    segpage_alu u_alu (
        .op(q.op), .acc(q.acc), .operand(rdata), .result(alu_out)
    );

    segpage_mem #(.AW(AW), .DW(DW)) u_mem (
        .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
        .raddr(xaddr), .rdata(rdata), .paddr(peek_addr), .pdata(peek_data)
    );

    always_comb begin
        d       = q;
        cpu_we  = 1'b0;
        seg_sel = 1'b0;
        off_sel = q.pc;
        phase   = PH_DATA;

        unique case (q.st)
            ST_F_SB, ST_O_SB: phase = PH_SEGBASE;
            ST_F_SL, ST_O_SL: phase = PH_SEGLEN;
            ST_F_PT, ST_O_PT: phase = PH_PTE;
            default:          phase = PH_DATA;
        endcase

        if (q.st inside {ST_O_SB, ST_O_SL, ST_O_PT, ST_O_AC}) begin
            seg_sel = 1'b1;
            off_sel = q.opnd;
        end

        len_bad = ({{(DW-OFF_W){1'b0}}, off_sel} >= rdata);

        unique case (q.st)
            ST_IDLE, ST_HALT, ST_FAULT: begin
                if (start) begin
                    d.st  = ST_F_SB;
                    d.pc  = '0;
                    d.stb = stbl_base;
                    d.ptb = ptbl_base;
                end
            end
            ST_F_SB: begin
                d.sbase = rdata[AW-1:0];
                d.st    = ST_F_SL;
            end
            ST_F_SL: d.st = len_bad ? ST_FAULT : ST_F_PT;
            ST_F_PT: begin
                d.frame = rdata[FR_W-1:0];
                d.st    = ST_F_RD;
            end
            ST_F_RD: begin
                d.op   = rdata[DW-1:DW-OP_W];
                d.opnd = rdata[OFF_W-1:0];
                d.pc   = q.pc + 1'b1;
                unique case (rdata[DW-1:DW-OP_W])
                    OP_HALT:                          d.st = ST_HALT;
                    OP_LOAD, OP_ADD, OP_SUB, OP_STORE: d.st = ST_O_SB;
                    default:                          d.st = ST_F_SB;
                endcase
            end
            ST_O_SB: begin
                d.sbase = rdata[AW-1:0];
                d.st    = ST_O_SL;
            end
            ST_O_SL: d.st = len_bad ? ST_FAULT : ST_O_PT;
            ST_O_PT: begin
                d.frame = rdata[FR_W-1:0];
                d.st    = ST_O_AC;
            end
            ST_O_AC: begin
                d.acc  = alu_out;
                cpu_we = (q.op == OP_STORE);
                d.st   = ST_F_SB;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_comb begin
        mem_we    = cpu_we | (ld_we & ~busy);
        mem_waddr = cpu_we ? xaddr : ld_addr;
        mem_wdata = cpu_we ? q.acc : ld_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign acc    = q.acc;
    assign busy   = !(q.st inside {ST_IDLE, ST_HALT, ST_FAULT});
    assign halted = (q.st == ST_HALT) || (q.st == ST_FAULT);
    assign fault  = (q.st == ST_FAULT);
endmodule

// File: rtl/segpage_cpu_chk.sv
module segpage_cpu_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       busy,
    input logic       halted,
    input logic       fault,
    input logic [7:0] acc,
    input logic       cpu_we
);
    p_halt_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        halted && !start |=> halted);

    p_acc_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        halted && !start |=> $stable(acc));

    p_fault_halts_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> halted);

    p_busy_not_halted_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && halted));

    p_write_in_run_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_we |-> busy);

    p_start_launches_r11: assert property (@(posedge clk) disable iff (!rst_n)
        start && !busy |=> busy && !halted && !fault);
endmodule

bind segpage_cpu segpage_cpu_chk u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
    .halted(halted), .fault(fault), .acc(acc), .cpu_we(cpu_we)
);

// File: tb/segpage_cpu_test.sv
module segpage_cpu_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [4:0] stbl_base = '0;
    logic [4:0] ptbl_base = '0;
    logic       ld_we = 1'b0;
    logic [4:0] ld_addr = '0;
    logic [7:0] ld_data = '0;
    logic [4:0] peek_addr = '0;
    logic [7:0] peek_data;
    logic [7:0] acc;
    logic       busy, halted, fault;

    int n_checks = 0;
    int n_fail   = 0;

    typedef struct { int kind; int addr; int exp; string req; } item_t;
    item_t sb_q[$];

    segpage_cpu uut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .stbl_base(stbl_base), .ptbl_base(ptbl_base),
        .ld_we(ld_we), .ld_addr(ld_addr), .ld_data(ld_data),
        .peek_addr(peek_addr), .peek_data(peek_data),
        .acc(acc), .busy(busy), .halted(halted), .fault(fault)
    );

    always #2 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // driver side: expected results into the scoreboard
    task automatic push(input int kind, input int addr, input int exp, input string req);
        item_t it;
        it.kind = kind; it.addr = addr; it.exp = exp; it.req = req;
        sb_q.push_back(it);
    endtask

    // monitor side: compare each queued item with what the design shows
    task automatic drain();
        item_t it;
        int act;
        while (sb_q.size() > 0) begin
            it = sb_q.pop_front();
            case (it.kind)
                0: begin peek_addr = it.addr[4:0]; #1; act = int'(peek_data); end
                1: act = int'(acc);
                2: act = int'(fault);
                default: act = int'(halted);
            endcase
            chk(it.req, act, it.exp);
        end
    endtask

    task automatic poke(input int a, input int v);
        @(negedge clk);
        ld_we = 1'b1; ld_addr = a[4:0]; ld_data = v[7:0];
        @(negedge clk);
        ld_we = 1'b0;
    endtask

    // shared image: descriptors at 0, page table at 4, code at 12, data at 20
    task automatic load_base();
        for (int i = 0; i < 32; i++) poke(i, 0);
        poke(0, 0);  poke(1, 8);  poke(2, 16); poke(3, 8);
        poke(4, 3);  poke(5, 4);  poke(8, 5);  poke(9, 6);
    endtask

    task automatic run(input int sb, input int pb, input bit inject, output int cyc);
        @(negedge clk);
        stbl_base = sb[4:0]; ptbl_base = pb[4:0]; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        chk("R11 busy after start", int'(busy), 1);
        chk("R11 halted cleared", int'(halted), 0);
        chk("R11 fault cleared", int'(fault), 0);
        cyc = 0;
        while (cyc < 2000) begin
            @(posedge clk);
            cyc++;
            @(negedge clk);
            if (inject && cyc == 3) begin
                ld_we = 1'b1; ld_addr = 5'd10; ld_data = 8'h77;
            end
            if (cyc == 4) ld_we = 1'b0;
            if (halted) break;
        end
    endtask

    initial begin
        #(4 * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        int cyc;
        repeat (3) @(negedge clk);
        chk("R1 acc reset", int'(acc), 0);
        chk("R1 busy reset", int'(busy), 0);
        chk("R1 halted reset", int'(halted), 0);
        chk("R1 fault reset", int'(fault), 0);
        rst_n = 1'b1;

        // A: load/add/sub/store, ignored bit 4, no-op opcode, halt
        load_base();
        poke(12, 8'h20); poke(13, 8'h51); poke(14, 8'h62); poke(15, 8'h83);
        poke(16, 8'hA4); poke(17, 8'hE0);
        poke(20, 8'hF0); poke(21, 8'h20); poke(22, 8'h30); poke(24, 8'h55);
        push(1, 0, 8'hE0, "R2 acc after load/add/sub wrap");
        push(0, 23, 8'hE0, "R3 stored value at frame 5 byte 3");
        push(0, 22, 8'h30, "R3 operand unchanged");
        push(0, 24, 8'h55, "R8 opcode 101 wrote nothing");
        push(2, 0, 0, "R7 no fault on halt");
        push(3, 0, 1, "R7 halted");
        run(0, 4, 1'b0, cyc);
        chk("R9 cycle count 4x8+4+4", cyc, 40);
        drain();
        repeat (10) @(negedge clk);
        chk("R7 halted holds", int'(halted), 1);
        chk("R7 acc holds", int'(acc), 8'hE0);

        // B1: data offset equal to length faults, prior load kept
        load_base();
        poke(12, 8'h27); poke(13, 8'h28); poke(27, 8'h9C);
        push(1, 0, 8'h9C, "R6 acc kept after data fault");
        push(2, 0, 1, "R6 fault on offset == length");
        push(3, 0, 1, "R6 halted on fault");
        run(0, 4, 1'b0, cyc);
        chk("R9 data fault timing", cyc, 14);
        drain();

        // B2: code segment of length 1 faults on second fetch
        load_base();
        poke(1, 1); poke(12, 8'h21); poke(21, 8'h20);
        push(1, 0, 8'h20, "R5 first fetch at offset 0");
        push(2, 0, 1, "R6 code offset fault");
        run(0, 4, 1'b0, cyc);
        chk("R9 code fault timing", cyc, 10);
        drain();

        // C: descriptors at 28, write attempt during run
        load_base();
        poke(0, 8'hFF); poke(1, 8'hFF); poke(2, 8'hFF); poke(3, 8'hFF);
        poke(28, 0); poke(29, 8); poke(30, 16); poke(31, 8);
        poke(12, 8'h25); poke(13, 8'h86); poke(14, 8'hE0); poke(25, 8'h3C);
        push(0, 26, 8'h3C, "R4 descriptors at nonzero base");
        push(1, 0, 8'h3C, "R4 acc via relocated table");
        push(0, 10, 0, "R10 load port ignored while busy");
        push(2, 0, 0, "R4 no fault");
        run(28, 4, 1'b1, cyc);
        drain();

        // D: linear address wraps mod 32 into page 0
        load_base();
        poke(2, 30); poke(12, 8'h23); poke(13, 8'hE0);
        push(1, 0, 8'hE0, "R4 wrapped linear address to phys 13");
        push(3, 0, 1, "R7 halted after wrap test");
        run(0, 4, 1'b0, cyc);
        chk("R9 load plus halt timing", cyc, 12);
        drain();

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule